// File: doc/BRIEF.md
# Wide Free-Running Counter with Self-Rearming Compare

This block keeps a 64-bit up-counter and a single 64-bit compare channel, both reached through a plain 32-bit register bus with word addresses. Software loads the counter one 32-bit half at a time and sets a run bit to let it count, one step per clock. The halves are not captured together. To read the counter while it runs, software reads the upper half, then the lower half, then the upper half again, and retries if the two upper reads differ.

The compare channel flags a pending event whenever it is enabled and the counter equals the compare value. The flag is set even when the interrupt is masked. In periodic mode, each match also adds a 32-bit step to the compare value, so events recur at a fixed spacing without any software action.

Each write that software must see land is confirmed by a sticky write-status flag. The flag rises a fixed number of cycles after the write, which stands for the crossing into the timer clock domain. Software clears a flag by writing 1 to it.

Top module: `wide_cmp_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low.
- R2: Writing address 0 replaces counter bits 31:0, and writing address 1 replaces bits 63:32. In a cycle that carries such a write, the counter does not also count. Addresses 0 and 1 read back the two halves.
- R3: The counter adds 1 on every clock while control bit 0 (run) is set, holds while it is clear, and wraps from all ones to zero.
- R4: Addresses 4 and 5 hold the low and high halves of the compare value, and address 6 holds the 32-bit periodic step. All three read back what was written.
- R5: In any cycle where control bit 16 (compare enable) is set and the counter equals the compare value, bit 0 of address 9 (event status) is set on the next clock. The interrupt enable has no effect on this.
- R6: When control bit 17 (periodic) is set, a match adds the step to the compare value on the same clock. A software write to a compare half in that cycle takes precedence over the addition.
- R7: `irq_o` equals status bit 0 AND bit 0 of address 8 (interrupt enable).
- R8: Writing 1 to bit 0 of address 9 clears the event status, and writing 0 leaves it unchanged. If a match occurs in the same cycle as the clear, the status stays set.
- R9: Address 2 holds the counter write flags. Bit 0 confirms a write to address 0 and bit 1 confirms a write to address 1. Each flag is set WS_DELAY clocks after the write's clock edge.
- R10: Address 7 holds the global write flags, with the same WS_DELAY delay as R9. Bit 16 confirms a write to address 3, and bits 0, 1 and 2 confirm writes to addresses 4, 5 and 6.
- R11: A write flag is cleared by writing 1 to its bit. Writing 0 leaves it unchanged. If a new confirmation lands in the same cycle as the clear, the flag stays set.
- R12: Address 3 (control) keeps only bits 0, 16 and 17. Address 8 keeps only bit 0. All other bits of every register, and every address from 10 to 15, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Write strobe for one cycle |
| bus_addr_i | input | 4 | Word address for both read and write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Compare interrupt, status AND enable |

## Verification
The hardest case to reach from the ports is a status clear that lands in the same cycle as a fresh match, because a running counter passes the compare value in one cycle. The bench forces this case by stopping the counter at a value equal to the compare value with the comparator enabled. A match then occurs on every cycle, so the clear write must lose. The periodic mode and the 64-bit wrap are set up directly by preloading the counter just below the match point or below all ones. Random write and read traffic then mixes clears, confirmations and matches at varied spacings, and a cycle model in the bench predicts every result.

// File: rtl/wct_pkg.sv
package wct_pkg;
    localparam int ADDR_W = 4;
    typedef logic [ADDR_W-1:0] reg_addr_t;

    localparam reg_addr_t A_CNT_LO  = 4'd0;
    localparam reg_addr_t A_CNT_HI  = 4'd1;
    localparam reg_addr_t A_CNT_WS  = 4'd2;
    localparam reg_addr_t A_CTRL    = 4'd3;
    localparam reg_addr_t A_CMP_LO  = 4'd4;
    localparam reg_addr_t A_CMP_HI  = 4'd5;
    localparam reg_addr_t A_CMP_INC = 4'd6;
    localparam reg_addr_t A_GLB_WS  = 4'd7;
    localparam reg_addr_t A_IRQ_EN  = 4'd8;
    localparam reg_addr_t A_IRQ_ST  = 4'd9;

    localparam int CTRL_RUN    = 0;
    localparam int CTRL_CMP_EN = 16;
    localparam int CTRL_AUTO   = 17;

    localparam int CWS_W      = 2;
    localparam int GWS_CMP_LO = 0;
    localparam int GWS_CMP_HI = 1;
    localparam int GWS_INCR   = 2;
    localparam int GWS_CTRL   = 16;
    localparam int GWS_W      = 17;
endpackage

// File: rtl/wct_counter.sv
module wct_counter #(
    parameter int HALF_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_i,
    input  logic                  wr_lo_i,
    input  logic                  wr_hi_i,
    input  logic [HALF_W-1:0]     wdata_i,
    output logic [2*HALF_W-1:0]   cnt_o
);
    localparam int CW = 2 * HALF_W;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lo_i) st_d.cnt[HALF_W-1:0] = wdata_i;
        if (wr_hi_i) st_d.cnt[CW-1:HALF_W] = wdata_i;
        if (!wr_lo_i && !wr_hi_i && run_i) st_d.cnt = st_q.cnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !wr_lo_i && !wr_hi_i) |=> (cnt_o == $past(cnt_o) + CW'(1))); // R3
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_o)); // R3
    AST_CNT_LOAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo_i |=> (cnt_o[HALF_W-1:0] == $past(wdata_i))); // R2
endmodule

// File: rtl/wct_compare.sv
module wct_compare #(
    parameter int HALF_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*HALF_W-1:0]   cnt_i,
    input  logic                  en_i,
    input  logic                  auto_i,
    input  logic                  wr_lo_i,
    input  logic                  wr_hi_i,
    input  logic                  wr_incr_i,
    input  logic                  clr_i,
    input  logic [HALF_W-1:0]     wdata_i,
    output logic [2*HALF_W-1:0]   cmp_o,
    output logic [HALF_W-1:0]     incr_o,
    output logic                  stat_o
);
    localparam int CW = 2 * HALF_W;

    typedef struct packed {
        logic [CW-1:0]     cmp;
        logic [HALF_W-1:0] incr;
        logic              stat;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        hit  = en_i && (cnt_i == st_q.cmp);
        st_d = st_q;
        if (wr_lo_i || wr_hi_i) begin
            if (wr_lo_i) st_d.cmp[HALF_W-1:0] = wdata_i;
            if (wr_hi_i) st_d.cmp[CW-1:HALF_W] = wdata_i;
        end else if (hit && auto_i) begin
            st_d.cmp = st_q.cmp + {{HALF_W{1'b0}}, st_q.incr};
        end
        if (wr_incr_i) st_d.incr = wdata_i;
        st_d.stat = hit | (st_q.stat & ~clr_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp_o  = st_q.cmp;
    assign incr_o = st_q.incr;
    assign stat_o = st_q.stat;

    AST_MATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && cnt_i == cmp_o) |=> stat_o); // R5
    AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(en_i && cnt_i == cmp_o)) |=> !stat_o); // R8
    AST_AUTO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && auto_i && cnt_i == cmp_o && !wr_lo_i && !wr_hi_i)
        |=> (cmp_o == $past(cmp_o) + {{HALF_W{1'b0}}, $past(incr_o)})); // R6
    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo_i && !wr_hi_i && !(en_i && auto_i && cnt_i == cmp_o)) |=> $stable(cmp_o)); // R4
endmodule

// File: rtl/wct_wstat.sv
module wct_wstat #(
    parameter int NFLAG = 2,
    parameter int DELAY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] hit_i,
    input  logic [NFLAG-1:0] clr_i,
    output logic [NFLAG-1:0] flags_o
);
    localparam int LAST = DELAY - 1;

    typedef struct packed {
        logic [DELAY-1:0][NFLAG-1:0] pend;
        logic [NFLAG-1:0]            flags;
    } ws_state_t;

    ws_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pend[0] = hit_i;
        for (int k = 1; k < DELAY; k++) begin
            st_d.pend[k] = st_q.pend[k-1];
        end
        st_d.flags = st_q.pend[LAST] | (st_q.flags & ~clr_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    AST_WS_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (|st_q.pend[LAST]) |=> ((flags_o & $past(st_q.pend[LAST])) == $past(st_q.pend[LAST]))); // R9
    AST_WS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flags_o) & ~$past(clr_i) & ~flags_o) == '0)); // R11
endmodule

// File: rtl/wide_cmp_timer.sv
module wide_cmp_timer #(
    parameter int BUS_W    = 32,
    parameter int WS_DELAY = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr_i,
    input  logic [wct_pkg::ADDR_W-1:0] bus_addr_i,
    input  logic [BUS_W-1:0]         bus_wdata_i,
    output logic [BUS_W-1:0]         bus_rdata_o,
    output logic                     irq_o
);
    import wct_pkg::*;

    localparam int CW = 2 * BUS_W;

    typedef struct packed {
        logic run;
        logic cmp_en;
        logic auto_inc;
        logic irq_en;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic wr_cnt_lo, wr_cnt_hi, wr_cnt_ws, wr_ctrl;
    logic wr_cmp_lo, wr_cmp_hi, wr_cmp_inc, wr_glb_ws;
    logic wr_irq_en, wr_irq_st;

    logic [CW-1:0]    cnt;
    logic [CW-1:0]    cmp;
    logic [BUS_W-1:0] incr;
    logic             stat;
    logic [CWS_W-1:0] cws_flags, cws_hit, cws_clr;
    logic [GWS_W-1:0] gws_flags, gws_hit, gws_clr;

    always_comb begin
        wr_cnt_lo  = bus_wr_i && (bus_addr_i == A_CNT_LO);
        wr_cnt_hi  = bus_wr_i && (bus_addr_i == A_CNT_HI);
        wr_cnt_ws  = bus_wr_i && (bus_addr_i == A_CNT_WS);
        wr_ctrl    = bus_wr_i && (bus_addr_i == A_CTRL);
        wr_cmp_lo  = bus_wr_i && (bus_addr_i == A_CMP_LO);
        wr_cmp_hi  = bus_wr_i && (bus_addr_i == A_CMP_HI);
        wr_cmp_inc = bus_wr_i && (bus_addr_i == A_CMP_INC);
        wr_glb_ws  = bus_wr_i && (bus_addr_i == A_GLB_WS);
        wr_irq_en  = bus_wr_i && (bus_addr_i == A_IRQ_EN);
        wr_irq_st  = bus_wr_i && (bus_addr_i == A_IRQ_ST);
    end

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.run      = bus_wdata_i[CTRL_RUN];
            st_d.cmp_en   = bus_wdata_i[CTRL_CMP_EN];
            st_d.auto_inc = bus_wdata_i[CTRL_AUTO];
        end
        if (wr_irq_en) st_d.irq_en = bus_wdata_i[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cws_hit = {wr_cnt_hi, wr_cnt_lo};
        cws_clr = wr_cnt_ws ? bus_wdata_i[CWS_W-1:0] : '0;
        gws_hit = '0;
        gws_hit[GWS_CMP_LO] = wr_cmp_lo;
        gws_hit[GWS_CMP_HI] = wr_cmp_hi;
        gws_hit[GWS_INCR]   = wr_cmp_inc;
        gws_hit[GWS_CTRL]   = wr_ctrl;
        gws_clr = wr_glb_ws ? bus_wdata_i[GWS_W-1:0] : '0;
    end

    wct_counter #(.HALF_W(BUS_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (st_q.run),
        .wr_lo_i (wr_cnt_lo),
        .wr_hi_i (wr_cnt_hi),
        .wdata_i (bus_wdata_i),
        .cnt_o   (cnt)
    );

    wct_compare #(.HALF_W(BUS_W)) u_compare (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_i     (cnt),
        .en_i      (st_q.cmp_en),
        .auto_i    (st_q.auto_inc),
        .wr_lo_i   (wr_cmp_lo),
        .wr_hi_i   (wr_cmp_hi),
        .wr_incr_i (wr_cmp_inc),
        .clr_i     (wr_irq_st && bus_wdata_i[0]),
        .wdata_i   (bus_wdata_i),
        .cmp_o     (cmp),
        .incr_o    (incr),
        .stat_o    (stat)
    );

    wct_wstat #(.NFLAG(CWS_W), .DELAY(WS_DELAY)) u_cnt_ws (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (cws_hit),
        .clr_i   (cws_clr),
        .flags_o (cws_flags)
    );

    wct_wstat #(.NFLAG(GWS_W), .DELAY(WS_DELAY)) u_glb_ws (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (gws_hit),
        .clr_i   (gws_clr),
        .flags_o (gws_flags)
    );

    assign irq_o = stat && st_q.irq_en;

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_CNT_LO:  bus_rdata_o = cnt[BUS_W-1:0];
            A_CNT_HI:  bus_rdata_o = cnt[CW-1:BUS_W];
            A_CNT_WS:  bus_rdata_o[CWS_W-1:0] = cws_flags;
            A_CTRL: begin
                bus_rdata_o[CTRL_RUN]    = st_q.run;
                bus_rdata_o[CTRL_CMP_EN] = st_q.cmp_en;
                bus_rdata_o[CTRL_AUTO]   = st_q.auto_inc;
            end
            A_CMP_LO:  bus_rdata_o = cmp[BUS_W-1:0];
            A_CMP_HI:  bus_rdata_o = cmp[CW-1:BUS_W];
            A_CMP_INC: bus_rdata_o = incr;
            A_GLB_WS:  bus_rdata_o[GWS_W-1:0] = gws_flags;
            A_IRQ_EN:  bus_rdata_o[0] = st_q.irq_en;
            A_IRQ_ST:  bus_rdata_o[0] = stat;
            default:   bus_rdata_o = '0;
        endcase
    end

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> st_q.irq_en); // R7
    AST_CTRL_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (st_q.run == $past(bus_wdata_i[CTRL_RUN]))); // R12
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i > A_IRQ_ST) |-> (bus_rdata_o == '0)); // R12
endmodule

// File: tb/wide_cmp_timer_bench.sv
module wide_cmp_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WSD        = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wide_cmp_timer #(.BUS_W(32), .WS_DELAY(WSD)) u_wide_cmp_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq)
    );

    // Cycle model built from the requirements
    logic [63:0] m_cnt, m_cmp;
    logic [31:0] m_incr;
    logic        m_run, m_en, m_auto, m_ien, m_stat;
    logic [1:0]  m_cws;
    logic [16:0] m_gws;
    logic [1:0]  m_cp [WSD];
    logic [16:0] m_gp [WSD];

    always @(posedge clk) begin
        logic w, match;
        logic [3:0] a;
        logic [31:0] d;
        logic [63:0] n_cnt, n_cmp;
        logic [1:0] ch;
        logic [16:0] gh;
        if (!rst_n) begin
            m_cnt = '0; m_cmp = '0; m_incr = '0;
            m_run = 0; m_en = 0; m_auto = 0; m_ien = 0; m_stat = 0;
            m_cws = '0; m_gws = '0;
            for (int k = 0; k < WSD; k++) begin m_cp[k] = '0; m_gp[k] = '0; end
        end else begin
            w = bus_wr; a = bus_addr; d = bus_wdata;
            match = m_en && (m_cnt == m_cmp);
            n_cnt = m_cnt;
            if (w && a == 0) n_cnt[31:0] = d;
            if (w && a == 1) n_cnt[63:32] = d;
            if (!(w && (a == 0 || a == 1)) && m_run) n_cnt = m_cnt + 64'd1;
            n_cmp = m_cmp;
            if (w && a == 4) n_cmp[31:0] = d;
            if (w && a == 5) n_cmp[63:32] = d;
            if (!(w && (a == 4 || a == 5)) && match && m_auto) n_cmp = m_cmp + {32'd0, m_incr};
            if (w && a == 6) m_incr = d;
            if (w && a == 3) begin m_run = d[0]; m_en = d[16]; m_auto = d[17]; end
            if (w && a == 8) m_ien = d[0];
            m_stat = match | (m_stat & !(w && a == 9 && d[0]));
            m_cws = m_cp[WSD-1] | (m_cws & ~((w && a == 2) ? d[1:0] : 2'b0));
            m_gws = m_gp[WSD-1] | (m_gws & ~((w && a == 7) ? d[16:0] : 17'b0));
            ch = {w && a == 1, w && a == 0};
            gh = '0;
            gh[0] = w && a == 4; gh[1] = w && a == 5; gh[2] = w && a == 6; gh[16] = w && a == 3;
            for (int k = WSD-1; k > 0; k--) begin m_cp[k] = m_cp[k-1]; m_gp[k] = m_gp[k-1]; end
            m_cp[0] = ch; m_gp[0] = gh;
            m_cnt = n_cnt; m_cmp = n_cmp;
        end
    end

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a)
            4'd0: return m_cnt[31:0];
            4'd1: return m_cnt[63:32];
            4'd2: return {30'd0, m_cws};
            4'd3: return {14'd0, m_auto, m_en, 15'd0, m_run};
            4'd4: return m_cmp[31:0];
            4'd5: return m_cmp[63:32];
            4'd6: return m_incr;
            4'd7: return {15'd0, m_gws};
            4'd8: return {31'd0, m_ien};
            4'd9: return {31'd0, m_stat};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'd0, 4'd1: return "R2";
            4'd2: return "R9";
            4'd4, 4'd5, 4'd6: return "R4";
            4'd7: return "R10";
            4'd8: return "R7";
            4'd9: return "R5";
            default: return "R12";
        endcase
    endfunction

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_reg(input logic [3:0] a, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #1;
        exp = model_read(a);
        checks++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL %s addr %0d: actual %h expected %h", tag, a, bus_rdata, exp);
        end
        checks++;
        if (irq !== (m_stat & m_ien)) begin
            fails++;
            $display("FAIL R7 irq: actual %b expected %b", irq, m_stat & m_ien);
        end
    endtask

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary_and_end();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 16; a++) check_reg(4'(a), "R1");

        // R2 counter preload, R9 confirmation timing
        bus_write(4'd0, 32'h1234_5678);
        check_reg(4'd2, "R9");
        bus_write(4'd1, 32'h0000_00AB);
        check_reg(4'd0, "R2");
        check_reg(4'd1, "R2");
        check_reg(4'd2, "R9");
        // R11 write-1-to-clear, write 0 ignored
        bus_write(4'd2, 32'h0);
        check_reg(4'd2, "R11");
        bus_write(4'd2, 32'h3);
        check_reg(4'd2, "R11");

        // R12 control keeps only three bits; R10 confirmation
        bus_write(4'd3, 32'hFFFE_FFFE);
        check_reg(4'd3, "R12");
        idle(WSD);
        check_reg(4'd7, "R10");
        bus_write(4'd7, 32'h0001_0000);
        check_reg(4'd7, "R11");
        bus_write(4'd8, 32'hFFFF_FFFE);
        check_reg(4'd8, "R12");
        check_reg(4'd12, "R12");

        // R3 wrap at 64 bits
        bus_write(4'd3, 32'h0);
        bus_write(4'd0, 32'hFFFF_FFFD);
        bus_write(4'd1, 32'hFFFF_FFFF);
        bus_write(4'd3, 32'h1);
        idle(5);
        check_reg(4'd1, "R3");
        check_reg(4'd0, "R3");
        bus_write(4'd3, 32'h0);
        idle(3);
        check_reg(4'd0, "R3");

        // R5 one-shot match with interrupt masked, then R7 unmask
        bus_write(4'd0, 32'd0);
        bus_write(4'd1, 32'd0);
        bus_write(4'd4, 32'd30);
        bus_write(4'd5, 32'd0);
        bus_write(4'd8, 32'd0);
        bus_write(4'd3, 32'h0001_0001);
        idle(40);
        check_reg(4'd9, "R5");
        bus_write(4'd8, 32'd1);
        check_reg(4'd9, "R7");
        bus_write(4'd9, 32'd0);
        check_reg(4'd9, "R8");
        bus_write(4'd9, 32'd1);
        check_reg(4'd9, "R8");

        // R6 periodic re-arm
        bus_write(4'd3, 32'h0);
        bus_write(4'd0, 32'd0);
        bus_write(4'd6, 32'd9);
        bus_write(4'd4, 32'd20);
        bus_write(4'd3, 32'h0003_0001);
        for (int i = 0; i < 12; i++) begin
            check_reg(4'd4, "R6");
            check_reg(4'd9, "R6");
            if (m_stat) bus_write(4'd9, 32'd1);
        end

        // R8 clear colliding with a standing match
        bus_write(4'd3, 32'h0);
        bus_write(4'd0, 32'd500);
        bus_write(4'd4, 32'd500);
        bus_write(4'd5, 32'd0);
        bus_write(4'd1, 32'd0);
        bus_write(4'd3, 32'h0001_0000);
        idle(2);
        bus_write(4'd9, 32'd1);
        check_reg(4'd9, "R8");
        bus_write(4'd3, 32'h0);
        bus_write(4'd9, 32'd1);
        check_reg(4'd9, "R8");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic [3:0] a;
            logic [31:0] d;
            r = int'($urandom % 10);
            if (r < 5) begin
                a = 4'($urandom % 11);
                d = $urandom;
                case (a)
                    4'd0, 4'd4: d = $urandom % 64;
                    4'd1, 4'd5: d = ($urandom % 8 == 0) ? 32'd1 : 32'd0;
                    4'd6: d = $urandom % 16;
                    default: ;
                endcase
                bus_write(a, d);
            end else begin
                a = 4'($urandom % 16);
                check_reg(a, tag_of(a));
            end
        end

        summary_and_end();
    end
endmodule